// File: doc/BRIEF.md
# Flash command launch controller

This block sits between a register write port and a small embedded flash model. Software loads a command word and its arguments into a bank of parameter slots through a slot index register. It then writes a one to the launch bit of the status register, which launches the command only while the command-complete flag is high. Every launch is checked in the cycle it is written. An illegal launch raises the access-error flag and runs nothing. An accepted launch drops the command-complete flag until the operation ends.

Three commands exist. The first is a blank check of both storage blocks, the main array and the data-EEPROM array, at one word per clock. Its result lands in a two-bit status pair. The second programs one word. The third erases both blocks back to all ones. A read of the array while a command owns the addressed block returns zero in place of data and raises two fault flags.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, cmd_done is 1, and acc_err, prot_viol, mg_stat, fault_single and fault_double are all 0. The whole array reads as all ones.
- R2: Address 1 is the status register. A write with bit 7 set while cmd_done is 1 launches the command. cmd_done is 0 from the launch edge until the command ends. The blank check ends with cmd_done rising exactly P_WORDS+E_WORDS clocks after the launch edge.
- R3: A program (0x06) or erase-all (0x08) launched before any write to address 0 (the clock-divider register) sets acc_err and runs nothing. The blank check (0x01) needs no such write.
- R4: A slot-0 value other than 0x01, 0x06 or 0x08 sets acc_err at launch and runs nothing.
- R5: The slot index (address 2) must be 0 at launch for 0x01 and 0x08, and 2 for 0x06. Any other index sets acc_err. Address 3 writes the slot selected by the index.
- R6: While acc_err or prot_viol is set, any launch sets acc_err and runs nothing. Writing bit 5 of the status register clears acc_err, and writing bit 4 clears prot_viol.
- R7: After a rejected launch, cmd_done returns to 1 one clock after the launch edge, and mg_stat is 00.
- R8: A blank check of an array holding only all-ones words gives mg_stat 00. A word holding a 0 bit in either block gives 11. Every accepted launch clears mg_stat.
- R9: During a blank check, scan_err_fix set on a scanned word sets mg_stat bit 1 only. scan_err_fatal sets both bits.
- R10: Program 0x06 writes slot 2 to the word addressed by slot 1. The launch sets acc_err if that word is not all ones or lies outside the array. It sets prot_viol, without writing, when the address lies in PROT_LO..PROT_HI. Only a program launch can set prot_viol.
- R11: Erase-all 0x08 returns every word in both blocks to all ones.
- R12: A read (rd_en) while cmd_done is 0, to a block the running command uses, returns 0 on rd_data the next cycle and sets fault_single and fault_double. A program uses only the block holding its target. A read to the other block returns stored data. Address 4 clears the fault flags by write-1: bit 0 clears fault_single and bit 1 clears fault_double.
- R13: Writes to addresses 0, 2 and 3 while cmd_done is 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 divider, 1 status, 2 slot index, 3 slot data, 4 fault clear) |
| reg_wdata | input | WORD_W | Register write data |
| rd_en | input | 1 | Array read request |
| rd_addr | input | AW | Array word address (main block below P_WORDS, then EEPROM) |
| scan_err_fix | input | 1 | Correctable read error reported for the word being scanned |
| scan_err_fatal | input | 1 | Non-correctable read error reported for the word being scanned |
| rd_data | output | WORD_W | Read data, one cycle after rd_en |
| cmd_done | output | 1 | Command-complete flag |
| acc_err | output | 1 | Access-error flag |
| prot_viol | output | 1 | Protection-violation flag |
| mg_stat | output | 2 | Blank-check and read-error status pair |
| fault_single | output | 1 | Single-fault flag from reads during a busy command |
| fault_double | output | 1 | Double-fault flag from reads during a busy command |

## Verification
The assertions assume that the scan error inputs matter only while a blank check runs. They also assume that software never launches while cmd_done is low, because the block treats such a write as no launch. The clean-status checks further assume that no fault-clear write lands in the same cycle as a busy read. The bench drives the scan error inputs only around a blank check, and it never clears faults during a busy read. It waits for cmd_done before each new launch, except in the scenarios that probe busy behaviour on purpose.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   localparam logic [7:0] CMD_BLANK_ALL = 8'h01;
   localparam logic [7:0] CMD_PROG_WORD = 8'h06;
   localparam logic [7:0] CMD_ERASE_ALL = 8'h08;

   localparam logic [2:0] RA_DIVIDER  = 3'd0;
   localparam logic [2:0] RA_STATUS   = 3'd1;
   localparam logic [2:0] RA_SLOT_IDX = 3'd2;
   localparam logic [2:0] RA_SLOT_DAT = 3'd3;
   localparam logic [2:0] RA_FAULT    = 3'd4;

   localparam int BIT_GO       = 7;
   localparam int BIT_CLR_ACC  = 5;
   localparam int BIT_CLR_PROT = 4;
   localparam int BIT_CLR_SGL  = 0;
   localparam int BIT_CLR_DBL  = 1;

   typedef enum logic [2:0] {
      OP_IDLE,
      OP_BLANK,
      OP_PROG,
      OP_ERASE,
      OP_ABORT
   } op_e;

endpackage

// File: rtl/flash_array.sv
module flash_array #(
   parameter int WORD_W  = 16,
   parameter int P_WORDS = 32,
   parameter int E_WORDS = 16,
   localparam int TOTAL  = P_WORDS + E_WORDS,
   localparam int AW     = $clog2(TOTAL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              erase_all,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   input  logic [AW-1:0]     chk_addr,
   input  logic [AW-1:0]     scan_addr,
   output logic [WORD_W-1:0] rd_word,
   output logic              chk_blank,
   output logic              scan_blank
);

   logic [WORD_W-1:0] mem [TOTAL];
   logic [TOTAL-1:0]  blank;

   always_ff @(posedge clk) begin
      if (!rst_n || erase_all) begin
         for (int i = 0; i < TOTAL; i++) mem[i] <= '1;
      end else if (wr_en && (wr_addr < AW'(TOTAL))) begin
         mem[wr_addr] <= wr_data;
      end
   end

   for (genvar g = 0; g < TOTAL; g++) begin : g_blank
      assign blank[g] = &mem[g];
   end

   assign rd_word    = (rd_addr < AW'(TOTAL))   ? mem[rd_addr]     : '0;
   assign chk_blank  = (chk_addr < AW'(TOTAL))  ? blank[chk_addr]  : 1'b0;
   assign scan_blank = (scan_addr < AW'(TOTAL)) ? blank[scan_addr] : 1'b0;

   // program into a non-erased word must have been stopped at launch
   assert_prog_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> blank[wr_addr]);

endmodule

// File: rtl/flash_scan.sv
module flash_scan #(
   parameter int TOTAL = 48,
   localparam int AW   = $clog2(TOTAL)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          active,
   output logic          last,
   output logic [AW-1:0] addr
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         addr   <= '0;
      end else if (start) begin
         active <= 1'b1;
         addr   <= '0;
      end else if (active) begin
         if (last) active <= 1'b0;
         else      addr   <= addr + 1'b1;
      end
   end

   assign last = active && (addr == AW'(TOTAL - 1));

   assert_scan_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (addr < AW'(TOTAL)));

   assert_scan_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (last && !start) |=> !active);

endmodule

// File: rtl/flash_launch_chk.sv
module flash_launch_chk
   import flash_cmd_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter int P_WORDS = 32,
   parameter int E_WORDS = 16,
   parameter int NSLOT   = 3,
   parameter int PROT_LO = 24,
   parameter int PROT_HI = 31,
   localparam int TOTAL  = P_WORDS + E_WORDS,
   localparam int IDX_W  = $clog2(NSLOT)
) (
   input  logic [WORD_W-1:0] code,
   input  logic [IDX_W-1:0]  idx,
   input  logic [WORD_W-1:0] tgt,
   input  logic              tgt_blank,
   input  logic              div_ok,
   input  logic              err_pending,
   output logic              acc_fail,
   output logic              prot_fail,
   output op_e               op
);

   logic is_blank, is_prog, is_erase, bad_idx, tgt_in, tgt_prot;

   assign is_blank = (code == WORD_W'(CMD_BLANK_ALL));
   assign is_prog  = (code == WORD_W'(CMD_PROG_WORD));
   assign is_erase = (code == WORD_W'(CMD_ERASE_ALL));
   assign tgt_in   = (tgt < WORD_W'(TOTAL));
   assign tgt_prot = (tgt >= WORD_W'(PROT_LO)) && (tgt <= WORD_W'(PROT_HI));

   always_comb begin
      bad_idx = 1'b0;
      op      = OP_ABORT;
      if (is_blank) begin
         op      = OP_BLANK;
         bad_idx = (idx != IDX_W'(0));
      end else if (is_prog) begin
         op      = OP_PROG;
         bad_idx = (idx != IDX_W'(2));
      end else if (is_erase) begin
         op      = OP_ERASE;
         bad_idx = (idx != IDX_W'(0));
      end
   end

   assign acc_fail = err_pending
                   | !(is_blank | is_prog | is_erase)
                   | bad_idx
                   | ((is_prog | is_erase) & !div_ok)
                   | (is_prog & (!tgt_in | !tgt_blank));

   assign prot_fail = !acc_fail & is_prog & tgt_prot;

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
   import flash_cmd_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter int P_WORDS = 32,
   parameter int E_WORDS = 16,
   parameter int NSLOT   = 3,
   parameter int PROT_LO = 24,
   parameter int PROT_HI = 31,
   localparam int TOTAL  = P_WORDS + E_WORDS,
   localparam int AW     = $clog2(TOTAL),
   localparam int IDX_W  = $clog2(NSLOT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   input  logic              rd_en,
   input  logic [AW-1:0]     rd_addr,
   input  logic              scan_err_fix,
   input  logic              scan_err_fatal,
   output logic [WORD_W-1:0] rd_data,
   output logic              cmd_done,
   output logic              acc_err,
   output logic              prot_viol,
   output logic [1:0]        mg_stat,
   output logic              fault_single,
   output logic              fault_double
);

   if (WORD_W < 8)                      begin : g_bad_width $error("WORD_W below 8"); end
   if (NSLOT < 3)                       begin : g_bad_slots $error("NSLOT below 3"); end
   if (P_WORDS < 1 || E_WORDS < 1)      begin : g_bad_size  $error("empty block"); end
   if (PROT_LO > PROT_HI || PROT_HI >= TOTAL) begin : g_bad_prot $error("bad protected range"); end

   logic [WORD_W-1:0] slot [NSLOT];
   logic [IDX_W-1:0]  slot_idx;
   logic              div_ok;
   op_e               op_q, chk_op;
   logic [1:0]        busy_mask;

   logic we_div, we_stat, we_idx, we_dat, we_flt, launch;
   logic acc_fail, prot_fail, accept;
   logic chk_blank, scan_blank, scan_active, scan_last;
   logic [AW-1:0]     scan_addr, tgt_addr;
   logic [WORD_W-1:0] arr_word;
   logic              tgt_blk, rd_blk, bad_rd;

   assign we_div  = reg_we && (reg_addr == RA_DIVIDER);
   assign we_stat = reg_we && (reg_addr == RA_STATUS);
   assign we_idx  = reg_we && (reg_addr == RA_SLOT_IDX);
   assign we_dat  = reg_we && (reg_addr == RA_SLOT_DAT);
   assign we_flt  = reg_we && (reg_addr == RA_FAULT);
   assign launch  = we_stat && reg_wdata[BIT_GO] && cmd_done;
   assign accept  = launch && !acc_fail && !prot_fail;

   assign tgt_addr = slot[1][AW-1:0];
   assign tgt_blk  = (tgt_addr >= AW'(P_WORDS));
   assign rd_blk   = (rd_addr  >= AW'(P_WORDS));
   assign bad_rd   = rd_en && !cmd_done && busy_mask[rd_blk];

   flash_launch_chk #(
      .WORD_W(WORD_W), .P_WORDS(P_WORDS), .E_WORDS(E_WORDS),
      .NSLOT(NSLOT), .PROT_LO(PROT_LO), .PROT_HI(PROT_HI)
   ) u_chk (
      .code        (slot[0]),
      .idx         (slot_idx),
      .tgt         (slot[1]),
      .tgt_blank   (chk_blank),
      .div_ok      (div_ok),
      .err_pending (acc_err | prot_viol),
      .acc_fail    (acc_fail),
      .prot_fail   (prot_fail),
      .op          (chk_op)
   );

   flash_scan #(.TOTAL(TOTAL)) u_scan (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (accept && (chk_op == OP_BLANK)),
      .active (scan_active),
      .last   (scan_last),
      .addr   (scan_addr)
   );

   flash_array #(.WORD_W(WORD_W), .P_WORDS(P_WORDS), .E_WORDS(E_WORDS)) u_arr (
      .clk        (clk),
      .rst_n      (rst_n),
      .erase_all  (op_q == OP_ERASE),
      .wr_en      (op_q == OP_PROG),
      .wr_addr    (tgt_addr),
      .wr_data    (slot[2]),
      .rd_addr    (rd_addr),
      .chk_addr   (tgt_addr),
      .scan_addr  (scan_addr),
      .rd_word    (arr_word),
      .chk_blank  (chk_blank),
      .scan_blank (scan_blank)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_done     <= 1'b1;
         acc_err      <= 1'b0;
         prot_viol    <= 1'b0;
         mg_stat      <= 2'b00;
         fault_single <= 1'b0;
         fault_double <= 1'b0;
         div_ok       <= 1'b0;
         slot_idx     <= '0;
         op_q         <= OP_IDLE;
         busy_mask    <= 2'b00;
         rd_data      <= '0;
         for (int i = 0; i < NSLOT; i++) slot[i] <= '0;
      end else begin
         if (we_div && cmd_done) div_ok <= 1'b1;
         if (we_idx && cmd_done) slot_idx <= reg_wdata[IDX_W-1:0];
         if (we_dat && cmd_done && (slot_idx < IDX_W'(NSLOT))) slot[slot_idx] <= reg_wdata;

         if (we_stat && reg_wdata[BIT_CLR_ACC])  acc_err   <= 1'b0;
         if (we_stat && reg_wdata[BIT_CLR_PROT]) prot_viol <= 1'b0;

         case (op_q)
            OP_BLANK: begin
               if (!scan_blank || scan_err_fatal) mg_stat    <= 2'b11;
               else if (scan_err_fix)             mg_stat[1] <= 1'b1;
               if (scan_last) begin
                  cmd_done  <= 1'b1;
                  op_q      <= OP_IDLE;
                  busy_mask <= 2'b00;
               end
            end
            OP_PROG, OP_ERASE, OP_ABORT: begin
               cmd_done  <= 1'b1;
               op_q      <= OP_IDLE;
               busy_mask <= 2'b00;
            end
            default: ;
         endcase

         if (launch) begin
            cmd_done <= 1'b0;
            mg_stat  <= 2'b00;
            if (acc_fail) begin
               acc_err   <= 1'b1;
               op_q      <= OP_ABORT;
               busy_mask <= 2'b00;
            end else if (prot_fail) begin
               prot_viol <= 1'b1;
               op_q      <= OP_ABORT;
               busy_mask <= 2'b00;
            end else begin
               op_q      <= chk_op;
               busy_mask <= (chk_op == OP_PROG) ? (tgt_blk ? 2'b10 : 2'b01) : 2'b11;
            end
         end

         if (we_flt && reg_wdata[BIT_CLR_SGL]) fault_single <= 1'b0;
         if (we_flt && reg_wdata[BIT_CLR_DBL]) fault_double <= 1'b0;
         if (bad_rd) begin
            fault_single <= 1'b1;
            fault_double <= 1'b1;
         end

         if (rd_en) rd_data <= bad_rd ? '0 : arr_word;
      end
   end

   assert_done_falls_on_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmd_done) |-> $past(launch));

   assert_accept_clears_stat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (mg_stat == 2'b00) && !cmd_done);

   assert_reject_returns_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && acc_fail) |=> acc_err && !cmd_done ##1 cmd_done);

   assert_prot_only_program_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prot_viol) |-> $past(launch && (slot[0] == WORD_W'(CMD_PROG_WORD))));

   assert_busy_read_faults_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_rd && !we_flt) |=> fault_single && fault_double && (rd_data == '0));

   assert_busy_idx_ignored_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (we_idx && !cmd_done) |=> $stable(slot_idx));

endmodule

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;

   localparam int WORD_W = 16;
   localparam int TOTAL  = 48;
   localparam int AW     = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_we = 1'b0;
   logic [2:0]        reg_addr = '0;
   logic [WORD_W-1:0] reg_wdata = '0;
   logic              rd_en = 1'b0;
   logic [AW-1:0]     rd_addr = '0;
   logic              scan_err_fix = 1'b0;
   logic              scan_err_fatal = 1'b0;
   logic [WORD_W-1:0] rd_data;
   logic              cmd_done, acc_err, prot_viol, fault_single, fault_double;
   logic [1:0]        mg_stat;

   int nvec = 0;
   int nfail = 0;

   always #10 clk = ~clk;

   flash_cmd_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .rd_en(rd_en), .rd_addr(rd_addr),
      .scan_err_fix(scan_err_fix), .scan_err_fatal(scan_err_fatal),
      .rd_data(rd_data), .cmd_done(cmd_done), .acc_err(acc_err),
      .prot_viol(prot_viol), .mg_stat(mg_stat),
      .fault_single(fault_single), .fault_double(fault_double)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [15:0] q);
      rd_en = 1'b1; rd_addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      q = rd_data;
   endtask

   task automatic set_cmd(input logic [15:0] code, input logic [15:0] a,
                          input logic [15:0] d, input int nidx);
      wr(3'd2, 16'd0); wr(3'd3, code);
      if (nidx >= 1) begin wr(3'd2, 16'd1); wr(3'd3, a); end
      if (nidx >= 2) begin wr(3'd2, 16'd2); wr(3'd3, d); end
   endtask

   task automatic go();
      wr(3'd1, 16'h0080);
   endtask

   task automatic wait_done(input string req, input int exp_cycles);
      int n = 0;
      while (!cmd_done && n < 500) begin @(negedge clk); n++; end
      if (exp_cycles >= 0) check(req, 16'(n), 16'(exp_cycles));
   endtask

   task automatic expect_reject(input string req);
      check({req, " acc_err"}, {15'd0, acc_err}, 16'd1);
      check({req, " done low"}, {15'd0, cmd_done}, 16'd0);
      @(negedge clk);
      check({req, " done back"}, {15'd0, cmd_done}, 16'd1);
      check({req, " mg cleared R7"}, {14'd0, mg_stat}, 16'd0);
      wr(3'd1, 16'h0030);
      check({req, " cleared R6"}, {14'd0, acc_err, prot_viol}, 16'd0);
   endtask

   task automatic blank_check(input string req, input logic [1:0] exp_mg);
      set_cmd(16'h0001, 16'd0, 16'd0, 0);
      go();
      check({req, " busy R2"}, {15'd0, cmd_done}, 16'd0);
      wait_done({req, " cycles R2"}, TOTAL);
      check({req, " status"}, {14'd0, mg_stat}, {14'd0, exp_mg});
      check({req, " no prot R10"}, {15'd0, prot_viol}, 16'd0);
   endtask

   task automatic t_reset();
      logic [15:0] q;
      check("R1 done", {15'd0, cmd_done}, 16'd1);
      check("R1 flags", {11'd0, acc_err, prot_viol, mg_stat, fault_single, fault_double}, 16'd0);
      rd(6'd0, q);  check("R1 main erased", q, 16'hFFFF);
      rd(6'd47, q); check("R1 eeprom erased", q, 16'hFFFF);
   endtask

   task automatic t_no_divider();
      blank_check("R3 verify without divider", 2'b00);
      set_cmd(16'h0006, 16'd5, 16'h1234, 2); go(); expect_reject("R3 program");
      set_cmd(16'h0008, 16'd0, 16'd0, 0);    go(); expect_reject("R3 erase");
      wr(3'd0, 16'h0010);
   endtask

   task automatic t_bad_code_idx();
      set_cmd(16'h0055, 16'd0, 16'd0, 0);    go(); expect_reject("R4 unknown");
      set_cmd(16'h0001, 16'd0, 16'd0, 1);    go(); expect_reject("R5 verify idx1");
      set_cmd(16'h0006, 16'd5, 16'h0, 1);    go(); expect_reject("R5 program idx1");
   endtask

   task automatic t_program();
      logic [15:0] q;
      set_cmd(16'h0006, 16'd5, 16'h1234, 2); go();
      wait_done("R10 program", 1);
      check("R10 program no err", {15'd0, acc_err}, 16'd0);
      rd(6'd5, q); check("R10 readback", q, 16'h1234);
      blank_check("R8 main dirty", 2'b11);
      set_cmd(16'h0077, 16'd0, 16'd0, 0); go();
      check("R7 mg cleared at reject", {14'd0, mg_stat}, 16'd0);
      expect_reject("R4 second unknown");
      set_cmd(16'h0006, 16'd5, 16'h0000, 2); go(); expect_reject("R10 not erased");
      set_cmd(16'h0006, 16'd60, 16'h0000, 2); go(); expect_reject("R10 out of range");
      set_cmd(16'h0006, 16'd26, 16'h0000, 2); go();
      @(negedge clk);
      check("R10 prot flag", {15'd0, prot_viol}, 16'd1);
      check("R10 prot no acc", {15'd0, acc_err}, 16'd0);
      rd(6'd26, q); check("R10 protected untouched", q, 16'hFFFF);
   endtask

   task automatic t_pending();
      set_cmd(16'h0001, 16'd0, 16'd0, 0); go();
      check("R6 pending acc", {15'd0, acc_err}, 16'd1);
      @(negedge clk);
      check("R6 not run", {15'd0, cmd_done}, 16'd1);
      wr(3'd1, 16'h0010);
      check("R6 prot cleared", {15'd0, prot_viol}, 16'd0);
      go();
      check("R6 acc still blocks", {15'd0, acc_err}, 16'd1);
      @(negedge clk);
      wr(3'd1, 16'h0020);
      check("R6 acc cleared", {15'd0, acc_err}, 16'd0);
   endtask

   task automatic t_erase();
      logic [15:0] q;
      set_cmd(16'h0008, 16'd0, 16'd0, 0); go();
      wait_done("R11 erase", 1);
      rd(6'd5, q); check("R11 word erased", q, 16'hFFFF);
      blank_check("R11 blank after erase", 2'b00);
      set_cmd(16'h0006, 16'd40, 16'h00FF, 2); go(); wait_done("R10 eeprom program", 1);
      blank_check("R8 eeprom dirty", 2'b11);
      set_cmd(16'h0008, 16'd0, 16'd0, 0); go(); wait_done("R11 erase 2", 1);
      blank_check("R8 clean again", 2'b00);
   endtask

   task automatic t_scan_err();
      scan_err_fix = 1'b1;
      blank_check("R9 correctable", 2'b10);
      scan_err_fix = 1'b0; scan_err_fatal = 1'b1;
      blank_check("R9 fatal", 2'b11);
      scan_err_fatal = 1'b0;
      blank_check("R8 accept clears", 2'b00);
   endtask

   task automatic t_busy_read();
      logic [15:0] q;
      set_cmd(16'h0001, 16'd0, 16'd0, 0); go();
      rd(6'd3, q);
      check("R12 invalid data", q, 16'h0000);
      check("R12 faults set", {14'd0, fault_single, fault_double}, 16'd3);
      wait_done("R12 verify end", -1);
      wr(3'd4, 16'h0001);
      check("R12 clear single", {14'd0, fault_single, fault_double}, 16'd1);
      wr(3'd4, 16'h0002);
      check("R12 clear double", {14'd0, fault_single, fault_double}, 16'd0);
      set_cmd(16'h0006, 16'd5, 16'h00F0, 2); go();
      rd(6'd40, q);
      check("R12 other block ok", q, 16'hFFFF);
      check("R12 no fault", {14'd0, fault_single, fault_double}, 16'd0);
      set_cmd(16'h0006, 16'd6, 16'h000F, 2); go();
      rd(6'd6, q);
      check("R12 same block invalid", q, 16'h0000);
      check("R12 same block faults", {14'd0, fault_single, fault_double}, 16'd3);
      wr(3'd4, 16'h0003);
   endtask

   task automatic t_busy_writes();
      set_cmd(16'h0008, 16'd0, 16'd0, 0); go(); wait_done("R13 erase", 1);
      set_cmd(16'h0001, 16'd0, 16'd0, 0); go();
      wr(3'd3, 16'h0055);
      wr(3'd2, 16'h0002);
      wait_done("R13 first", -1);
      go();
      check("R13 writes ignored", {15'd0, acc_err}, 16'd0);
      wait_done("R13 second verify R2", TOTAL);
      check("R13 status", {14'd0, mg_stat}, 16'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_no_divider();
      t_bad_code_idx();
      t_program();
      t_pending();
      t_erase();
      t_scan_err();
      t_busy_read();
      t_busy_writes();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule